// File: doc/BRIEF.md
# Pseudo-static RAM access sequencer

This block sits between a synchronous host and an asynchronous 512K x 16 pseudo-static RAM. The host offers one word access at a time over a request/ready handshake. Each request carries a word address, write data, a two-bit lane mask and a read/write flag. The block turns each request into a chip-select, output-enable, write-enable and lane-strobe sequence. Every phase of that sequence lasts a whole number of clocks, worked out from the clock period and the speed grade. The memory pins are all driven from registers. The data bus is split into an outgoing word, an incoming word and a drive-enable, so a pad ring can build the bidirectional buffer outside the block.

The memory cells are dynamic and the device refreshes them itself, but only while it is deselected or between reads. For this reason the block opens no access until the device has finished its own start-up wait. Every write pulse has a fixed length well under the ceiling the device tolerates. After every access, chip select goes back high for a short gap, so back-to-back traffic always leaves the device room to refresh. Read data returns in a register with a one-cycle valid pulse. Lanes that were not requested read as zero.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `ready_o` stays low and `mem_cs1_n_o` stays high for at least ceil(PWRUP_NS / CLK_PERIOD_NS) clocks (6250 at the defaults), and `mem_cs2_o` is held low during that wait. No access starts before the wait has ended.
- R2: A request is taken only on a clock edge where `req_i` and `ready_o` are both high. A request raised during the start-up wait or while an access is running has no effect. Address, data and mask are latched when a request is taken, so host inputs that change later do not reach the memory pins.
- R3: A read drives `mem_cs1_n_o`=0, `mem_cs2_o`=1, `mem_we_n_o`=1 and `mem_oe_n_o`=0. Lane strobes are active low: `mem_lb_n_o` covers data[7:0] and is the inverse of mask bit 0, and `mem_ub_n_o` covers data[15:8] and is the inverse of mask bit 1. The read lasts the largest of the cycle time, address access time and output-enable access time, each rounded up to clocks. At 8 ns and the 55 ns grade this is 7 clocks.
- R4: Read data is sampled on the last clock edge of the read. `rvalid_o` is high for exactly one cycle, the first cycle after the read. `rdata_o` carries the memory lanes that were requested and zero in the lanes that were not.
- R5: A write drives `mem_cs1_n_o`=0, `mem_cs2_o`=1, `mem_oe_n_o`=1, `mem_we_n_o`=0 and `mem_dq_oe_o`=1, with the lane strobes set as in R3. The write lasts the largest of the pulse width, data setup, address setup, and write cycle time minus the gap, each in clocks. At the defaults this is 6 clocks. Address and outgoing data stay constant through the whole pulse.
- R6: `mem_dq_oe_o` is high only while `mem_we_n_o` is low and `mem_oe_n_o` is high. `mem_we_n_o` and `mem_oe_n_o` are never low together.
- R7: After every access, `mem_cs1_n_o` goes high with every strobe inactive for ceil(5 ns / CLK_PERIOD_NS) clocks before `ready_o` returns. Once it goes high, chip select stays high for at least two clocks.
- R8: No write-enable pulse lasts as long as 15 us.
- R9: `ready_o` is low whenever chip select is active. It goes high again on the clock after the deselect gap ends.
- R10: A write whose mask is 00 leaves both lane strobes high, so the stored word is unchanged, as a later read of that address shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| ready_o | output | 1 | Block can take a request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Lane mask, bit 0 = data[7:0], bit 1 = data[15:8] |
| rdata_o | output | 16 | Read data, unrequested lanes zero |
| rvalid_o | output | 1 | Read data valid, one cycle |
| mem_addr_o | output | 19 | Memory address |
| mem_cs1_n_o | output | 1 | Active-low chip select |
| mem_cs2_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_ub_n_o | output | 1 | Active-low upper lane strobe |
| mem_lb_n_o | output | 1 | Active-low lower lane strobe |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_i | input | 16 | Data from memory |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` |

## Verification
Two cases are hardest to reach from the ports. The first is a host that keeps requesting while an access is still running. The stimulus holds `req_i` high, and changes the address, data and mask, through every active cycle of an access. It drops the request only inside the deselect gap. The bench then checks that the memory pins never moved and that no second access started. The second case is proving that the lane mask is respected. The bench memory model returns a junk byte on any lane whose strobe is high and stores only the lanes that were strobed. Partial writes, a mask-00 write and partial reads therefore each show up in the returned word.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic cs1_n;
    logic cs2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } ctl_t;

  localparam int REFRESH_GAP_NS = 5;
  localparam int WPULSE_CEIL_NS = 15000;

  // whole clocks covering ns, never fewer than one
  function automatic int clk_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // device timing in ns; fast selects the quicker grade
  function automatic int t_rc(input bit fast);  return fast ? 55 : 70; endfunction
  function automatic int t_aa(input bit fast);  return fast ? 55 : 70; endfunction
  function automatic int t_doe(input bit fast); return fast ? 25 : 35; endfunction
  function automatic int t_pwe(input bit fast); return fast ? 45 : 60; endfunction
  function automatic int t_sd(input bit fast);  return fast ? 25 : 30; endfunction
  function automatic int t_aw(input bit fast);  return fast ? 45 : 60; endfunction
  function automatic int t_wc(input bit fast);  return fast ? 55 : 70; endfunction

endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int PWRUP_CYC = 6250,
  parameter int RD_CYC    = 7,
  parameter int WR_CYC    = 6,
  parameter int GAP_CYC   = 1,
  parameter int CNT_W     = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       wr_i,
  output seq_state_e state_nxt_o,
  output logic       accept_o,
  output logic       rd_last_o,
  output logic       ready_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ready_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    accept_o = 1'b0;
    case (state_q)
      ST_PWRUP: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          if (wr_i) begin
            state_d = ST_WRITE;
            cnt_d   = CNT_W'(WR_CYC - 1);
          end else begin
            state_d = ST_READ;
            cnt_d   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ, ST_WRITE: begin
        if (cnt_zero) begin
          state_d = ST_GAP;
          cnt_d   = CNT_W'(GAP_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      cnt_q   <= CNT_W'(PWRUP_CYC - 1);
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ready_q <= (state_d == ST_IDLE);
    end
  end

  assign state_nxt_o = state_d;
  assign rd_last_o   = (state_q == ST_READ) && cnt_zero;
  assign ready_o     = ready_q;
endmodule

// File: rtl/psram_bus.sv
module psram_bus
  import psram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  seq_state_e        state_nxt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic [LANES-1:0]  be_q_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output ctl_t              ctl_o,
  output logic [LANES-1:0]  lane_n_o
);
  localparam ctl_t CTL_RST = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1,
                               we_n: 1'b1, dq_oe: 1'b0};

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q, be_src;
  ctl_t              ctl_q, ctl_d;
  logic [LANES-1:0]  lane_q, lane_d;

  // request fields, enabled by acceptance only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  assign be_src = accept_i ? be_i : be_q;

  always_comb begin
    ctl_d  = '{cs1_n: 1'b1, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    lane_d = '1;
    case (state_nxt_i)
      ST_PWRUP: ctl_d.cs2 = 1'b0;
      ST_READ: begin
        ctl_d.cs1_n = 1'b0;
        ctl_d.oe_n  = 1'b0;
        lane_d      = ~be_src;
      end
      ST_WRITE: begin
        ctl_d.cs1_n = 1'b0;
        ctl_d.we_n  = 1'b0;
        ctl_d.dq_oe = 1'b1;
        lane_d      = ~be_src;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_RST;
      lane_q <= '1;
    end else begin
      ctl_q  <= ctl_d;
      lane_q <= lane_d;
    end
  end

  assign be_q_o     = be_q;
  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign ctl_o      = ctl_q;
  assign lane_n_o   = lane_q;
endmodule

// File: rtl/psram_capture.sv
module psram_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_last_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [7:0] lane_q [LANES];
  logic       rvalid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lane_q[g] <= 8'h00;
      else if (rd_last_i) lane_q[g] <= be_i[g] ? dq_i[g*8 +: 8] : 8'h00;
    end
    assign rdata_o[g*8 +: 8] = lane_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= rd_last_i;
  end

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter bit FAST_GRADE    = 1'b1,
  parameter int PWRUP_NS      = 50000,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs1_n_o,
  output logic              mem_cs2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_ub_n_o,
  output logic              mem_lb_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int LANES     = 2;
  localparam int GAP_CYC   = clk_cycles(REFRESH_GAP_NS, CLK_PERIOD_NS);
  localparam int RD_CYC    = imax(imax(clk_cycles(t_rc(FAST_GRADE), CLK_PERIOD_NS),
                                       clk_cycles(t_aa(FAST_GRADE), CLK_PERIOD_NS)),
                                  clk_cycles(t_doe(FAST_GRADE), CLK_PERIOD_NS));
  localparam int WR_BASE   = imax(imax(clk_cycles(t_pwe(FAST_GRADE), CLK_PERIOD_NS),
                                       clk_cycles(t_sd(FAST_GRADE), CLK_PERIOD_NS)),
                                  clk_cycles(t_aw(FAST_GRADE), CLK_PERIOD_NS));
  localparam int WR_CYC    = imax(WR_BASE,
                                  clk_cycles(t_wc(FAST_GRADE), CLK_PERIOD_NS) - GAP_CYC);
  localparam int PWRUP_CYC = clk_cycles(PWRUP_NS, CLK_PERIOD_NS);
  localparam int CNT_W     = $clog2(imax(PWRUP_CYC, imax(RD_CYC, WR_CYC)) + 1);

  logic             rst_sync_n;
  seq_state_e       state_nxt;
  logic             accept, rd_last;
  logic [LANES-1:0] be_q, lane_n;
  ctl_t             ctl;

  psram_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  psram_seq #(
    .PWRUP_CYC (PWRUP_CYC),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC),
    .GAP_CYC   (GAP_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .state_nxt_o (state_nxt),
    .accept_o    (accept),
    .rd_last_o   (rd_last),
    .ready_o     (ready_o)
  );

  psram_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .accept_i    (accept),
    .state_nxt_i (state_nxt),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .be_i        (be_i),
    .be_q_o      (be_q),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .ctl_o       (ctl),
    .lane_n_o    (lane_n)
  );

  psram_capture #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .rd_last_i (rd_last),
    .be_i      (be_q),
    .dq_i      (mem_dq_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign mem_cs1_n_o = ctl.cs1_n;
  assign mem_cs2_o   = ctl.cs2;
  assign mem_oe_n_o  = ctl.oe_n;
  assign mem_we_n_o  = ctl.we_n;
  assign mem_dq_oe_o = ctl.dq_oe;
  assign mem_ub_n_o  = lane_n[1];
  assign mem_lb_n_o  = lane_n[0];
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk
  import psram_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int PWRUP_NS      = 50000,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs1_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  localparam int PWRUP_CYC  = clk_cycles(PWRUP_NS, CLK_PERIOD_NS);
  localparam int WPULSE_MAX = (WPULSE_CEIL_NS - 1) / CLK_PERIOD_NS;

  logic [31:0] since_rst_q;
  logic [31:0] wlow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= '0;
      wlow_q      <= '0;
    end else begin
      if (since_rst_q < 32'(PWRUP_CYC)) since_rst_q <= since_rst_q + 1'b1;
      wlow_q <= mem_we_n_o ? 32'd0 : wlow_q + 1'b1;
    end
  end

  // R1
  pwrup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs1_n_o |-> since_rst_q >= 32'(PWRUP_CYC));

  // R6
  drive_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_n_o && mem_oe_n_o));

  // R6
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_n_o && !mem_oe_n_o));

  // R5
  write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> ($stable(mem_dq_o) && $stable(mem_addr_o)));

  // R8
  wpulse_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wlow_q <= 32'(WPULSE_MAX));

  // R9
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs1_n_o |-> !ready_o);

  // R7
  desel_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs1_n_o) |=> mem_cs1_n_o);

  // R4
  rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(!mem_oe_n_o));
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .PWRUP_NS      (PWRUP_NS),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs1_n_o (mem_cs1_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;
  localparam int CLK_NS = 8;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  // expected timing for the 55 ns grade, from the requirements
  int RD_N, WR_N, GAP_N, PWR_N;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr;
  logic [18:0] addr;
  logic [15:0] wdata;
  logic [1:0]  be;
  logic        ready, rvalid;
  logic [15:0] rdata;
  logic [18:0] mem_addr;
  logic        cs1_n, cs2, oe_n, we_n, ub_n, lb_n, dq_oe;
  logic [15:0] dq_out, dq_in;

  logic [15:0] pmem    [0:63];
  logic [15:0] exp_mem [0:63];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  psram_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .ready_o     (ready),
    .wr_i        (wr),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .be_i        (be),
    .rdata_o     (rdata),
    .rvalid_o    (rvalid),
    .mem_addr_o  (mem_addr),
    .mem_cs1_n_o (cs1_n),
    .mem_cs2_o   (cs2),
    .mem_oe_n_o  (oe_n),
    .mem_we_n_o  (we_n),
    .mem_ub_n_o  (ub_n),
    .mem_lb_n_o  (lb_n),
    .mem_dq_o    (dq_out),
    .mem_dq_i    (dq_in),
    .mem_dq_oe_o (dq_oe)
  );

  // pin-level memory: stores strobed lanes, returns junk on unstrobed lanes
  always @(negedge clk) begin
    if (!cs1_n && cs2 && !we_n && dq_oe) begin
      if (!lb_n) pmem[mem_addr[5:0]][7:0]  <= dq_out[7:0];
      if (!ub_n) pmem[mem_addr[5:0]][15:8] <= dq_out[15:8];
    end
    if (!cs1_n && cs2 && !oe_n && we_n)
      dq_in <= {ub_n ? 8'hEE : pmem[mem_addr[5:0]][15:8],
                lb_n ? 8'hEE : pmem[mem_addr[5:0]][7:0]};
    else
      dq_in <= 16'hDEAD;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pins();
    return {cs1_n, cs2, oe_n, we_n, ub_n, lb_n, dq_oe, ready};
  endfunction

  task automatic access(input bit w, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit hold);
    logic [15:0] expd;
    logic [7:0]  act_pins;
    int n;
    while (ready !== 1'b1) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; be = m;
    @(negedge clk);
    // R2: changed inputs must not reach the pins; with hold the request stays up
    addr = ~a; wdata = ~d; be = ~m;
    if (!hold) req = 1'b0;
    n = w ? WR_N : RD_N;
    act_pins = {1'b0, 1'b1, w, ~w, ~m[1], ~m[0], w, 1'b0};
    for (int i = 0; i < n; i++) begin
      chk(pins() == act_pins, w ? "R5 write strobes" : "R3 read strobes",
          32'(pins()), 32'(act_pins));
      chk(mem_addr == a && rvalid == 1'b0, "R2 latched address",
          32'(mem_addr), 32'(a));
      if (w) chk(dq_out == d, "R5 write data", 32'(dq_out), 32'(d));
      @(negedge clk);
    end
    req = 1'b0;
    if (w) begin
      if (m[0]) exp_mem[a[5:0]][7:0]  = d[7:0];
      if (m[1]) exp_mem[a[5:0]][15:8] = d[15:8];
    end
    expd = {m[1] ? exp_mem[a[5:0]][15:8] : 8'h00, m[0] ? exp_mem[a[5:0]][7:0] : 8'h00};
    for (int i = 0; i < GAP_N; i++) begin
      chk(pins() == 8'b1111_1100, "R7 deselect gap", 32'(pins()), 32'hFC);
      if (i == 0 && !w)
        chk(rvalid == 1'b1 && rdata == expd, "R4 read data",
            {15'd0, rvalid, rdata}, {16'd1, expd});
      else
        chk(rvalid == 1'b0, "R4 single valid pulse", 32'(rvalid), 32'd0);
      @(negedge clk);
    end
    chk(ready == 1'b1 && cs1_n == 1'b1 && rvalid == 1'b0, "R9 ready returns",
        {ready, cs1_n, rvalid}, 32'd6);
  endtask

  initial begin
    int cnt;
    bit bad;
    RD_N  = cdiv(55); if (cdiv(25) > RD_N) RD_N = cdiv(25);
    WR_N  = cdiv(45); if (cdiv(25) > WR_N) WR_N = cdiv(25);
    GAP_N = cdiv(5);
    if (cdiv(55) - GAP_N > WR_N) WR_N = cdiv(55) - GAP_N;
    PWR_N = cdiv(50000);
    for (int i = 0; i < 64; i++) begin pmem[i] = 16'h0; exp_mem[i] = 16'h0; end
    rst_n = 1'b0; req = 1'b1; wr = 1'b0; addr = 19'h3; wdata = 16'h0; be = 2'b11;
    repeat (4) @(negedge clk);
    chk(ready == 1'b0 && cs1_n == 1'b1 && rvalid == 1'b0 && dq_oe == 1'b0,
        "R1 reset state", {ready, cs1_n, rvalid, dq_oe}, 32'h4);
    rst_n = 1'b1;
    // R1/R2: wait with a request held for a while; it must be ignored
    cnt = 0; bad = 1'b0;
    while (ready !== 1'b1 && cnt < 20000) begin
      if (cs1_n !== 1'b1 || cs2 !== 1'b0) bad = 1'b1;
      if (cnt == 100) req = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk(!bad, "R1 deselected during wait", 32'(bad), 32'd0);
    chk(cnt >= PWR_N && cnt <= PWR_N + 3, "R1 wait length", cnt, PWR_N);
    bad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (cs1_n !== 1'b1 || ready !== 1'b1) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R2 early request not kept", 32'(bad), 32'd0);

    access(1'b1, 19'h00005, 16'hA5C3, 2'b11, 1'b0);
    access(1'b0, 19'h00005, 16'h0000, 2'b11, 1'b0);
    access(1'b1, 19'h00005, 16'h1234, 2'b01, 1'b0);
    access(1'b0, 19'h00005, 16'h0000, 2'b10, 1'b0);
    access(1'b0, 19'h00005, 16'h0000, 2'b01, 1'b1);
    // R10: mask 00 write leaves the word alone
    access(1'b1, 19'h00005, 16'hFFFF, 2'b00, 1'b1);
    access(1'b0, 19'h00005, 16'h0000, 2'b11, 1'b0);
    chk(rdata == 16'hA534, "R10 word unchanged", 32'(rdata), 32'hA534);
    access(1'b1, 19'h7FFFF, 16'hBEEF, 2'b10, 1'b0);
    access(1'b0, 19'h7FFFF, 16'h0000, 2'b11, 1'b0);
    chk(rdata == 16'hBE00, "R4 upper lane only stored", 32'(rdata), 32'hBE00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule